// File: doc/BRIEF.md
# Display Pipe Interrupt Aggregator

This block collects interrupt causes from two display pipes and two other sources: a command-completion event and a backlight-request event. Its outputs are a level interrupt line and a one-clock message pulse. Each pipe owns a status register. In that register, enable bits sit sixteen positions above the sticky status bits they govern. The enabled status bits of a pipe are ORed into a single pipe-event line. Only a rising edge of that line is reported onward.

A central stage holds a mask register, an enable register and an identity register, and all three are reached through a simple word-wide register port. An unmasked cause sets its identity bit, and software clears that bit by writing a one to it. The level output follows the identity bits that are enabled. The message pulse fires only when that set goes from empty to non-empty, so a handler must clear everything before a later cause can raise a new message. Each pipe also counts its vertical-blank pulses in a wrapping frame counter.

Top module: `dpipe_irq_agg`

## Requirements
- R1: After reset the mask reads 0xF (all four causes masked), the enable and identity registers read 0, both status registers read 0, both frame counters read 0, and irq_out and msi_out are low.
- R2: Status bits 31 and 15:0 of a pipe are sticky. A one on the matching bit of the pipe's hit input sets the bit. A vblank pulse sets bit 1. A bit stays set until a register write places a one at its position, and writing a zero there changes nothing. Hits on bits 30:16 are ignored.
- R3: When a status bit or an identity bit is set in the same cycle as a write that clears it, the bit ends up set.
- R4: Writing a status register stores wdata[30:16] as enable bits, and a read returns them in bits 30:16. Enable bit 16+i governs status bit i for i in 0..14. Status bits 15 and 31 have no enable.
- R5: A pipe's event line is the OR of its enabled status bits. On the clock edge after that line goes from 0 to 1, identity bit 2 (pipe A) or bit 3 (pipe B) is set if its mask bit is 0. While the line stays high, nothing further is set.
- R6: An event edge that occurs while its mask bit is 1 is lost. Clearing the mask afterwards does not set the identity bit.
- R7: A user_done pulse sets identity bit 0, and a backlight_evt pulse sets identity bit 1, each only when its mask bit is 0.
- R8: The identity register is cleared bit by bit by writing ones to it at address 4.
- R9: irq_out is high exactly when (identity AND enable) is nonzero.
- R10: msi_out is high for one cycle when (identity AND enable) changes from zero to nonzero. Causes added while that value is already nonzero give no pulse.
- R11: Each pipe's frame counter (FCNT_W bits, default 24) adds one on each vblank pulse of that pipe and wraps from all ones to zero.
- R12: The register addresses are 0 pipe A status, 1 pipe B status, 2 mask, 3 enable, 4 identity, 5 pipe A frame count and 6 pipe B frame count. Address 7 reads zero. Mask and enable use data bits 3:0. Writes to 5, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hit_a | input | 32 | Pipe A status set pulses, one per status bit |
| hit_b | input | 32 | Pipe B status set pulses |
| vblank_a | input | 1 | Pipe A vertical-blank pulse |
| vblank_b | input | 1 | Pipe B vertical-blank pulse |
| user_done | input | 1 | Command-completion pulse |
| backlight_evt | input | 1 | Backlight request pulse |
| irq_out | output | 1 | Level interrupt |
| msi_out | output | 1 | Message interrupt pulse |

## Verification
Directed sequences test the separate behaviours one at a time. A pipe edge that arrives while its cause is masked must be lost, while the same edge with the cause unmasked must be reported. A second cause arriving while the identity set is non-empty must give no message pulse, unlike a first cause. A write that clears a bit in the same cycle as a new hit must leave the bit set, unlike a plain clear. A long random phase then mixes hits, vblank pulses and register writes on every address. Its output is compared each cycle with a bench model, which covers event lines that rise while their enable is written, edges that stay high across several cycles, and frame counters wrapping in a reduced width.

// File: rtl/dpipe_irq_pkg.sv
package dpipe_irq_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned ID_W    = 4;
  localparam int unsigned EN_W    = 15;
  localparam int unsigned EN_LSB  = 16;
  localparam int unsigned VBL_BIT = 1;
  localparam logic [DW-1:0] STS_MASK = 32'h8000_FFFF;

  localparam int unsigned ID_USER  = 0;
  localparam int unsigned ID_BLC   = 1;
  localparam int unsigned ID_PIPE0 = 2;

  typedef enum logic [2:0] {
    RA_STAT_A = 3'd0,
    RA_STAT_B = 3'd1,
    RA_MASK   = 3'd2,
    RA_ENAB   = 3'd3,
    RA_IDENT  = 3'd4,
    RA_FCNT_A = 3'd5,
    RA_FCNT_B = 3'd6
  } reg_addr_e;

  // Event line of a pipe: any status bit whose enable is set.
  function automatic logic pipe_event(logic [DW-1:0] sts, logic [EN_W-1:0] en);
    return |(sts[EN_W-1:0] & en);
  endfunction

  // Sticky update with write-one-to-clear; new hits win.
  function automatic logic [DW-1:0] sticky_next(logic [DW-1:0] old,
                                                logic [DW-1:0] set,
                                                logic [DW-1:0] clr);
    return ((old & ~clr) | set) & STS_MASK;
  endfunction
endpackage

// File: rtl/dpipe_stat.sv
module dpipe_stat
  import dpipe_irq_pkg::*;
#(
  parameter int unsigned FCNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     hit,
  input  logic              vblank,
  output logic [DW-1:0]     rdata,
  output logic              evt_rise,
  output logic [FCNT_W-1:0] frame
);
  logic [DW-1:0]     sts_q;
  logic [EN_W-1:0]   en_q;
  logic              evt_q;
  logic [FCNT_W-1:0] fcnt_q;
  logic [DW-1:0]     set_v, clr_v;
  logic              evt_level;

  assign set_v     = (hit | (DW'(vblank) << VBL_BIT)) & STS_MASK;
  assign clr_v     = wr ? (wdata & STS_MASK) : '0;
  assign evt_level = pipe_event(sts_q, en_q);
  assign evt_rise  = evt_level & ~evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q  <= '0;
      en_q   <= '0;
      evt_q  <= 1'b0;
      fcnt_q <= '0;
    end else begin
      sts_q <= sticky_next(sts_q, set_v, clr_v);
      evt_q <= evt_level;
      if (wr)     en_q   <= wdata[EN_LSB +: EN_W];
      if (vblank) fcnt_q <= fcnt_q + 1'b1;
    end
  end

  assign rdata = sts_q | ({{(DW-EN_W){1'b0}}, en_q} << EN_LSB);
  assign frame = fcnt_q;

  // R2: a cleared position without a concurrent hit reads zero afterwards
  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ((sts_q & $past(clr_v & ~set_v)) == '0));
  // R3: every hit is visible after the edge, whatever was written
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((sts_q & $past(set_v)) == $past(set_v)));
  // R11: counter wraps to zero
  a_r11_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && (fcnt_q == '1)) |=> (fcnt_q == '0));
endmodule

// File: rtl/dpipe_id_ctrl.sv
module dpipe_id_ctrl
  import dpipe_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_wr,
  input  logic            enab_wr,
  input  logic            iden_wr,
  input  logic [DW-1:0]   wdata,
  input  logic [1:0]      pipe_rise,
  input  logic            user_evt,
  input  logic            blc_evt,
  output logic [ID_W-1:0] mask_q,
  output logic [ID_W-1:0] enab_q,
  output logic [ID_W-1:0] ident_q,
  output logic            irq_level,
  output logic            msi_pulse
);
  logic [ID_W-1:0] raw_v, set_v, clr_v;
  logic            irq_q;

  always_comb begin
    raw_v                 = '0;
    raw_v[ID_USER]        = user_evt;
    raw_v[ID_BLC]         = blc_evt;
    raw_v[ID_PIPE0 +: 2]  = pipe_rise;
  end

  assign set_v     = raw_v & ~mask_q;
  assign clr_v     = iden_wr ? wdata[ID_W-1:0] : '0;
  assign irq_level = |(ident_q & enab_q);
  assign msi_pulse = irq_level & ~irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      enab_q  <= '0;
      ident_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      ident_q <= (ident_q & ~clr_v) | set_v;
      irq_q   <= irq_level;
      if (mask_wr) mask_q <= wdata[ID_W-1:0];
      if (enab_wr) enab_q <= wdata[ID_W-1:0];
    end
  end

  // R10: message pulse is a single cycle and only with the level raised
  a_r10_msi_single: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |=> !msi_pulse);
  a_r10_msi_with_level: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> irq_level);
  // R6: pipe A identity bit only appears after an unmasked edge
  a_r6_masked_lost: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ident_q[ID_PIPE0]) |-> $past(pipe_rise[0] && !mask_q[ID_PIPE0]));
  // R8: written ones clear identity bits unless a cause arrives
  a_r8_ident_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    iden_wr |=> ((ident_q & $past(clr_v & ~set_v)) == '0));
endmodule

// File: rtl/dpipe_irq_agg.sv
module dpipe_irq_agg
  import dpipe_irq_pkg::*;
#(
  parameter int unsigned FCNT_W = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [31:0]   hit_a,
  input  logic [31:0]   hit_b,
  input  logic          vblank_a,
  input  logic          vblank_b,
  input  logic          user_done,
  input  logic          backlight_evt,
  output logic          irq_out,
  output logic          msi_out
);
  localparam int unsigned NPIPE = 2;

  logic [DW-1:0]     hit_arr  [NPIPE];
  logic              vbl_arr  [NPIPE];
  logic [DW-1:0]     stat_rd  [NPIPE];
  logic [FCNT_W-1:0] frame    [NPIPE];
  logic [NPIPE-1:0]  pipe_rise;
  logic [ID_W-1:0]   mask_q, enab_q, ident_q;

  assign hit_arr[0] = hit_a;
  assign hit_arr[1] = hit_b;
  assign vbl_arr[0] = vblank_a;
  assign vbl_arr[1] = vblank_b;

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    dpipe_stat #(.FCNT_W(FCNT_W)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_we && (reg_addr == 3'(p))),
      .wdata    (reg_wdata),
      .hit      (hit_arr[p]),
      .vblank   (vbl_arr[p]),
      .rdata    (stat_rd[p]),
      .evt_rise (pipe_rise[p]),
      .frame    (frame[p])
    );
  end

  dpipe_id_ctrl u_id (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr   (reg_we && (reg_addr == RA_MASK)),
    .enab_wr   (reg_we && (reg_addr == RA_ENAB)),
    .iden_wr   (reg_we && (reg_addr == RA_IDENT)),
    .wdata     (reg_wdata),
    .pipe_rise (pipe_rise),
    .user_evt  (user_done),
    .blc_evt   (backlight_evt),
    .mask_q    (mask_q),
    .enab_q    (enab_q),
    .ident_q   (ident_q),
    .irq_level (irq_out),
    .msi_pulse (msi_out)
  );

  always_comb begin
    case (reg_addr)
      RA_STAT_A: reg_rdata = stat_rd[0];
      RA_STAT_B: reg_rdata = stat_rd[1];
      RA_MASK:   reg_rdata = DW'(mask_q);
      RA_ENAB:   reg_rdata = DW'(enab_q);
      RA_IDENT:  reg_rdata = DW'(ident_q);
      RA_FCNT_A: reg_rdata = DW'(frame[0]);
      RA_FCNT_B: reg_rdata = DW'(frame[1]);
      default:   reg_rdata = '0;
    endcase
  end

  // R9: level output tracks enabled identity bits
  a_r9_level: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_out) |-> (($past(ident_q & enab_q) != '0) && ((ident_q & enab_q) == '0)));
endmodule

// File: tb/dpipe_irq_agg_tb.sv
module dpipe_irq_agg_tb;
  localparam int FW = 6;
  localparam logic [31:0] SM = 32'h8000_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, hit_a = '0, hit_b = '0;
  logic vblank_a = 1'b0, vblank_b = 1'b0, user_done = 1'b0, backlight_evt = 1'b0;
  logic [31:0] reg_rdata;
  logic irq_out, msi_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dpipe_irq_agg #(.FCNT_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hit_a(hit_a), .hit_b(hit_b),
    .vblank_a(vblank_a), .vblank_b(vblank_b), .user_done(user_done),
    .backlight_evt(backlight_evt), .irq_out(irq_out), .msi_out(msi_out));

  // bench model state
  logic [31:0]   m_sts [2];
  logic [14:0]   m_en  [2];
  logic          m_evq [2];
  logic [FW-1:0] m_fc  [2];
  logic [3:0]    m_mask, m_enab, m_id;
  logic          m_irq_q;

  function automatic bit lvl(logic [31:0] s, logic [14:0] e);
    for (int i = 0; i < 15; i++) if (s[i] && e[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_sts[0] | {1'b0, m_en[0], 16'h0};
      3'd1: return m_sts[1] | {1'b0, m_en[1], 16'h0};
      3'd2: return {28'h0, m_mask};
      3'd3: return {28'h0, m_enab};
      3'd4: return {28'h0, m_id};
      3'd5: return 32'(m_fc[0]);
      3'd6: return 32'(m_fc[1]);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R12";
      3'd4: return "R5";
      3'd5, 3'd6: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < 2; p++) begin
      m_sts[p] = '0; m_en[p] = '0; m_evq[p] = 1'b0; m_fc[p] = '0;
    end
    m_mask = 4'hF; m_enab = '0; m_id = '0; m_irq_q = 1'b0;
  endtask

  task automatic model_step();
    logic [3:0] raw, clr;
    logic [31:0] hs, setv, clrv;
    logic vb;
    raw = {1'b0, 1'b0, backlight_evt, user_done};
    for (int p = 0; p < 2; p++) raw[2+p] = lvl(m_sts[p], m_en[p]) && !m_evq[p];
    clr = (reg_we && reg_addr == 3'd4) ? reg_wdata[3:0] : 4'h0;
    m_irq_q = |(m_id & m_enab);
    m_id = (m_id & ~clr) | (raw & ~m_mask);
    if (reg_we && reg_addr == 3'd2) m_mask = reg_wdata[3:0];
    if (reg_we && reg_addr == 3'd3) m_enab = reg_wdata[3:0];
    for (int p = 0; p < 2; p++) begin
      hs = (p == 0) ? hit_a : hit_b;
      vb = (p == 0) ? vblank_a : vblank_b;
      m_evq[p] = lvl(m_sts[p], m_en[p]);
      setv = (hs | {30'h0, vb, 1'b0}) & SM;
      clrv = (reg_we && reg_addr == 3'(p)) ? (reg_wdata & SM) : 32'h0;
      m_sts[p] = ((m_sts[p] & ~clrv) | setv) & SM;
      if (reg_we && reg_addr == 3'(p)) m_en[p] = reg_wdata[30:16];
      if (vb) m_fc[p] = m_fc[p] + 1'b1;
    end
  endtask

  // One clock: compare outputs with the model, advance the model, cross the edge.
  task automatic cyc();
    logic in_now;
    #1;
    in_now = |(m_id & m_enab);
    chk("R9", {31'h0, irq_out}, {31'h0, in_now});
    chk("R10", {31'h0, msi_out}, {31'h0, in_now && !m_irq_q});
    chk(req_of(reg_addr), reg_rdata, exp_rd(reg_addr));
    model_step();
    @(posedge clk);
    #3;
    reg_we = 0; reg_wdata = '0; hit_a = '0; hit_b = '0;
    vblank_a = 0; vblank_b = 0; user_done = 0; backlight_evt = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; cyc();
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    reg_addr = a; #1; chk(req, reg_rdata, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #3; rst_n = 1;
    // R1: reset values
    rd_chk("R1", 3'd2, 32'hF);
    rd_chk("R1", 3'd3, 32'h0);
    rd_chk("R1", 3'd4, 32'h0);
    rd_chk("R1", 3'd0, 32'h0);
    rd_chk("R1", 3'd6, 32'h0);
    chk("R1", {30'h0, irq_out, msi_out}, 32'h0);

    // R6: masked pipe A edge is lost even after unmasking
    wr(3'd0, 32'h0002_0000);          // R4: enable status bit 1
    vblank_a = 1; cyc();              // status bit 1 set
    cyc();                            // edge happens while masked
    wr(3'd2, 32'h0);                  // unmask all
    cyc();
    rd_chk("R6", 3'd4, 32'h0);
    rd_chk("R4", 3'd0, 32'h0002_0002);

    // R5/R10: clear status, new vblank edge reaches identity and raises message
    wr(3'd3, 32'hF);
    wr(3'd0, 32'h0002_0002);          // clear bit 1, keep enable
    vblank_a = 1; cyc();
    cyc();                            // identity bit 2 set on this edge
    rd_chk("R5", 3'd4, 32'h4);
    chk("R10", {31'h0, msi_out}, 32'h1);
    chk("R9", {31'h0, irq_out}, 32'h1);
    // R10: second cause while nonzero gives no pulse
    user_done = 1; cyc();
    cyc();
    chk("R10", {31'h0, msi_out}, 32'h0);
    rd_chk("R7", 3'd4, 32'h5);
    // R3: identity set and clear in same cycle keeps bit
    reg_we = 1; reg_addr = 3'd4; reg_wdata = 32'h3; backlight_evt = 1; cyc();
    rd_chk("R3", 3'd4, 32'h6);
    // R3: status hit and clear in same cycle keeps bit
    reg_we = 1; reg_addr = 3'd1; reg_wdata = 32'h8000_0010; hit_b = 32'h0000_0010; cyc();
    rd_chk("R3", 3'd1, 32'h0000_0010);
    // R2: ignored hit positions, write zero keeps bits
    hit_b = 32'h7FFF_0000; cyc();
    wr(3'd1, 32'h0);
    rd_chk("R2", 3'd1, 32'h0000_0010);
    // R8: clear identity fully, level drops
    wr(3'd4, 32'hF);
    rd_chk("R8", 3'd4, 32'h0);
    chk("R9", {31'h0, irq_out}, 32'h0);
    // R12: write to counter address ignored, addr 7 reads zero
    wr(3'd5, 32'hFFFF_FFFF);
    rd_chk("R12", 3'd5, 32'(m_fc[0]));
    rd_chk("R12", 3'd7, 32'h0);
    // R11: wrap of reduced-width counter
    for (int i = 0; i < 70; i++) begin vblank_b = 1; cyc(); end
    rd_chk("R11", 3'd6, 32'(7'd70 % 7'd64));

    // random phase
    for (int n = 0; n < 4000; n++) begin
      reg_addr = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) begin
        reg_we = 1;
        reg_wdata = $urandom();
        if ($urandom_range(0, 1) == 0) reg_wdata = reg_wdata & 32'hFFFF_0003;
      end
      if ($urandom_range(0, 5) == 0) hit_a = $urandom() & 32'h8000_001F;
      if ($urandom_range(0, 5) == 0) hit_b = $urandom() & 32'h8000_001F;
      vblank_a = ($urandom_range(0, 7) == 0);
      vblank_b = ($urandom_range(0, 7) == 0);
      user_done = ($urandom_range(0, 15) == 0);
      backlight_evt = ($urandom_range(0, 15) == 0);
      cyc();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule